// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the execution datapath of a small 8-bit processor core. Each cycle it takes two byte operands, an operation code, a 6-bit immediate, a 3-bit bit index and the present status byte. It returns a result byte, a high result byte and the updated status byte. The register file, decoder and sequencing live outside the block. The caller feeds in the status byte it holds and writes back the status byte that the block returns.

The operations are byte add and subtract, increment, decrement and negate, the bitwise operations, shifts, rotates through carry and nibble swap. There is also a 16-bit add of a small immediate to a register pair, with the low byte on `a_i` and the high byte on `b_i`. Bit operations copy a register bit to or from the T flag, set or clear any status bit by its index, and read or write the whole status byte. All outputs are registered, so every result is due one clock after its inputs.

Top module: `alu8_status`

## Requirements
- R1: While `rst_ni` is low, `res_o`, `res_hi_o` and `sreg_o` are all zero.
- R2: Outputs change only on a rising clock edge. Each output reflects the inputs sampled at the previous rising edge. Status bits are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R3: Op 0 adds a+b and op 1 adds a+b+C. C is the carry out of bit 7, H is the carry out of bit 3, and V is the signed overflow.
- R4: Op 2 gives a-b and op 3 gives 0-a. For both, C is the borrow out of bit 7 and H is the borrow out of bit 3, and V is the signed overflow. Op 4 gives a+1 and op 5 gives a-1. These two set V on signed overflow and leave C and H unchanged.
- R5: Ops 6, 7 and 8 give a AND b, a OR b and a XOR b. Op 9 gives NOT a and sets C. All four clear V, and the first three leave C unchanged.
- R6: Op 10 shifts left and puts old bit 7 in C and old bit 3 in H. Op 11 shifts right with a zero fill. Op 12 shifts right and keeps bit 7. Ops 11 and 12 put old bit 0 in C. For all three shifts, V = N XOR C.
- R7: Op 13 rotates left, with C entering bit 0 and old bit 7 going to C and old bit 3 going to H. Op 14 rotates right, with C entering bit 7 and old bit 0 going to C. For both, V = N XOR C.
- R8: Op 15 exchanges the two nibbles of a and leaves the status unchanged.
- R9: Op 16 copies bit `sel_i` of a into T and passes a through. Op 17 writes T into bit `sel_i` of a and leaves the status unchanged.
- R10: Op 18 sets status bit `sel_i` and op 19 clears it. Both pass a through and leave the other status bits unchanged.
- R11: Op 20 returns {b,a}+k with k from 0 to 63, giving the low byte on `res_o` and the high byte on `res_hi_o`. C is the carry out of bit 15, V is set when the sum's bit 15 becomes 1 while b bit 7 was 0, N is bit 15, and Z flags a zero 16-bit sum.
- R12: Op 21 returns the status byte as the result. Op 22 loads a into the status byte. The I bit changes only through ops 18, 19 and 22.
- R13: For every operation that updates N, N is result bit 7 and S = N XOR V. Op codes 23 to 31 pass a through to `res_o` and leave the status unchanged. Outside op 20, `res_hi_o` is b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand, low byte of the pair |
| b_i | input | 8 | Second operand, high byte of the pair |
| k_i | input | 6 | Immediate for the pair add |
| sel_i | input | 3 | Bit index for bit and status operations |
| sreg_i | input | 8 | Current status byte |
| res_o | output | 8 | Result byte |
| res_hi_o | output | 8 | High result byte |
| sreg_o | output | 8 | Updated status byte |

## Verification
Every result and every flag is due exactly one rising edge after the inputs that produce it, and nothing is due earlier. The bench drives a new vector on each falling edge. One nanosecond later it confirms that the outputs still show the previous vector's values. At the next falling edge it compares all three outputs with a behavioural model of the vector. Directed vectors cover the carry, half-carry, overflow and zero boundaries and the pair-add wrap. Random vectors then run over all 32 op codes, including the unused ones.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IMM_W  = 6;
  localparam int unsigned SEL_W  = $clog2(DATA_W);
  localparam int unsigned OP_W   = 5;

  localparam int unsigned F_C = 0;
  localparam int unsigned F_Z = 1;
  localparam int unsigned F_N = 2;
  localparam int unsigned F_V = 3;
  localparam int unsigned F_S = 4;
  localparam int unsigned F_H = 5;
  localparam int unsigned F_T = 6;
  localparam int unsigned F_I = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_NEG  = 5'd3,
    OP_INC  = 5'd4,  OP_DEC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_LSL  = 5'd10, OP_LSR  = 5'd11,
    OP_ASR  = 5'd12, OP_ROL  = 5'd13, OP_ROR  = 5'd14, OP_SWAP = 5'd15,
    OP_BST  = 5'd16, OP_BLD  = 5'd17, OP_BSET = 5'd18, OP_BCLR = 5'd19,
    OP_ADIW = 5'd20, OP_SRD  = 5'd21, OP_SWR  = 5'd22
  } alu_op_e;

  typedef struct packed {
    logic              hit;
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] res_hi;
    logic [DATA_W-1:0] sreg;
  } unit_out_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  k_i,
  input  logic [DATA_W-1:0] sreg_i,
  output unit_out_t         out_o
);
  localparam int unsigned HALF = DATA_W / 2;
  localparam int unsigned WW   = 2 * DATA_W;

  logic [DATA_W-1:0] x, y, r;
  logic              cin, inv, upd_ch, v;
  logic [DATA_W:0]   sum;
  logic [HALF:0]     nib;
  logic [WW:0]       wsum;
  logic              wv;

  always_comb begin
    out_o.hit = 1'b1;
    x = a_i; y = b_i; cin = 1'b0; inv = 1'b0; upd_ch = 1'b1;
    case (op_i)
      OP_ADD: ;
      OP_ADC: cin = sreg_i[F_C];
      OP_SUB: begin y = ~b_i; cin = 1'b1; inv = 1'b1; end
      OP_NEG: begin x = '0; y = ~a_i; cin = 1'b1; inv = 1'b1; end
      OP_INC: begin y = DATA_W'(1); upd_ch = 1'b0; end
      OP_DEC: begin y = '1; upd_ch = 1'b0; end
      OP_ADIW: ;
      default: out_o.hit = 1'b0;
    endcase

    sum = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
    nib = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, cin};
    r   = sum[DATA_W-1:0];
    v   = (x[DATA_W-1] & y[DATA_W-1] & ~r[DATA_W-1]) |
          (~x[DATA_W-1] & ~y[DATA_W-1] & r[DATA_W-1]);

    wsum = {1'b0, b_i, a_i} + {{(WW+1-IMM_W){1'b0}}, k_i};
    wv   = ~b_i[DATA_W-1] & wsum[WW-1];

    out_o.sreg   = sreg_i;
    out_o.res_hi = b_i;
    if (op_i == OP_ADIW) begin
      out_o.res        = wsum[DATA_W-1:0];
      out_o.res_hi     = wsum[WW-1:DATA_W];
      out_o.sreg[F_C]  = wsum[WW];
      out_o.sreg[F_V]  = wv;
      out_o.sreg[F_N]  = wsum[WW-1];
      out_o.sreg[F_Z]  = (wsum[WW-1:0] == '0);
      out_o.sreg[F_S]  = wsum[WW-1] ^ wv;
    end else begin
      out_o.res = r;
      if (upd_ch) begin
        out_o.sreg[F_C] = sum[DATA_W] ^ inv;
        out_o.sreg[F_H] = nib[HALF] ^ inv;
      end
      out_o.sreg[F_V] = v;
      out_o.sreg[F_N] = r[DATA_W-1];
      out_o.sreg[F_Z] = (r == '0);
      out_o.sreg[F_S] = r[DATA_W-1] ^ v;
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] sreg_i,
  output unit_out_t         out_o
);
  localparam int unsigned MSB  = DATA_W - 1;
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] r;
  logic c, v, upd_nz, is_shift;

  always_comb begin
    out_o.hit    = 1'b1;
    out_o.res_hi = b_i;
    out_o.sreg   = sreg_i;
    r = a_i; c = sreg_i[F_C]; v = 1'b0; upd_nz = 1'b1; is_shift = 1'b0;
    case (op_i)
      OP_AND:  r = a_i & b_i;
      OP_OR:   r = a_i | b_i;
      OP_XOR:  r = a_i ^ b_i;
      OP_COM:  begin r = ~a_i; c = 1'b1; end
      OP_LSL:  begin r = {a_i[MSB-1:0], 1'b0}; c = a_i[MSB]; is_shift = 1'b1;
                     out_o.sreg[F_H] = a_i[HALF-1]; end
      OP_LSR:  begin r = {1'b0, a_i[MSB:1]}; c = a_i[0]; is_shift = 1'b1; end
      OP_ASR:  begin r = {a_i[MSB], a_i[MSB:1]}; c = a_i[0]; is_shift = 1'b1; end
      OP_ROL:  begin r = {a_i[MSB-1:0], sreg_i[F_C]}; c = a_i[MSB]; is_shift = 1'b1;
                     out_o.sreg[F_H] = a_i[HALF-1]; end
      OP_ROR:  begin r = {sreg_i[F_C], a_i[MSB:1]}; c = a_i[0]; is_shift = 1'b1; end
      OP_SWAP: begin r = {a_i[HALF-1:0], a_i[MSB:HALF]}; upd_nz = 1'b0; end
      default: begin out_o.hit = 1'b0; upd_nz = 1'b0; end
    endcase
    if (is_shift) v = r[MSB] ^ c;
    out_o.res = r;
    if (upd_nz) begin
      out_o.sreg[F_C] = c;
      out_o.sreg[F_V] = v;
      out_o.sreg[F_N] = r[MSB];
      out_o.sreg[F_Z] = (r == '0);
      out_o.sreg[F_S] = r[MSB] ^ v;
    end
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] sreg_i,
  output unit_out_t         out_o
);
  logic [DATA_W-1:0] bld_r, ns;
  logic is_bst, is_bld, is_set, is_clr, is_rd, is_wr;

  assign is_bst = (op_i == OP_BST);
  assign is_bld = (op_i == OP_BLD);
  assign is_set = (op_i == OP_BSET);
  assign is_clr = (op_i == OP_BCLR);
  assign is_rd  = (op_i == OP_SRD);
  assign is_wr  = (op_i == OP_SWR);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic here;
    assign here     = (sel_i == SEL_W'(i));
    assign bld_r[i] = (is_bld && here) ? sreg_i[F_T] : a_i[i];
    if (i == F_T) begin : g_t
      assign ns[i] = is_wr ? a_i[i] :
                     (is_set && here) ? 1'b1 :
                     (is_clr && here) ? 1'b0 :
                     is_bst ? a_i[sel_i] : sreg_i[i];
    end else begin : g_o
      assign ns[i] = is_wr ? a_i[i] :
                     (is_set && here) ? 1'b1 :
                     (is_clr && here) ? 1'b0 : sreg_i[i];
    end
  end

  assign out_o.hit    = is_bst | is_bld | is_set | is_clr | is_rd | is_wr;
  assign out_o.res    = is_rd ? sreg_i : bld_r;
  assign out_o.res_hi = b_i;
  assign out_o.sreg   = ns;
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        op_i,
  input  logic [7:0]        a_i,
  input  logic [7:0]        b_i,
  input  logic [5:0]        k_i,
  input  logic [2:0]        sel_i,
  input  logic [7:0]        sreg_i,
  output logic [7:0]        res_o,
  output logic [7:0]        res_hi_o,
  output logic [7:0]        sreg_o
);
  unit_out_t u_ar, u_sh, u_bt;
  logic [DATA_W-1:0] res_d, hi_d, sreg_d;

  alu_arith u_arith (.op_i(op_i), .a_i(a_i), .b_i(b_i), .k_i(k_i),
                     .sreg_i(sreg_i), .out_o(u_ar));
  alu_shift u_shift (.op_i(op_i), .a_i(a_i), .b_i(b_i),
                     .sreg_i(sreg_i), .out_o(u_sh));
  alu_bitops u_bits (.op_i(op_i), .a_i(a_i), .b_i(b_i), .sel_i(sel_i),
                     .sreg_i(sreg_i), .out_o(u_bt));

  always_comb begin
    res_d = a_i; hi_d = b_i; sreg_d = sreg_i;
    if (u_ar.hit) begin
      res_d = u_ar.res; hi_d = u_ar.res_hi; sreg_d = u_ar.sreg;
    end else if (u_sh.hit) begin
      res_d = u_sh.res; hi_d = u_sh.res_hi; sreg_d = u_sh.sreg;
    end else if (u_bt.hit) begin
      res_d = u_bt.res; hi_d = u_bt.res_hi; sreg_d = u_bt.sreg;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o    <= '0;
      res_hi_o <= '0;
      sreg_o   <= '0;
    end else begin
      res_o    <= res_d;
      res_hi_o <= hi_d;
      sreg_o   <= sreg_d;
    end
  end
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
  import alu_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] op_i,
  input logic [7:0] a_i,
  input logic [7:0] b_i,
  input logic [5:0] k_i,
  input logic [2:0] sel_i,
  input logic [7:0] sreg_i,
  input logic [7:0] res_o,
  input logic [7:0] res_hi_o,
  input logic [7:0] sreg_o
);
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (res_o == 8'h00 && sreg_o == 8'h00 && res_hi_o == 8'h00));

  p_sign_rule_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i <= 5'd14) |=> (sreg_o[F_S] == (sreg_o[F_N] ^ sreg_o[F_V])));

  p_swap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SWAP) |=>
      (res_o == {$past(a_i[3:0]), $past(a_i[7:4])} && sreg_o == $past(sreg_i)));

  p_bset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BSET) |=> (((sreg_o >> $past(sel_i)) & 8'h01) == 8'h01));

  p_bclr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BCLR) |=> (((sreg_o >> $past(sel_i)) & 8'h01) == 8'h00));

  p_pair_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADIW) |=> (sreg_o[F_Z] == ({res_hi_o, res_o} == 16'h0000)));

  p_iflag_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_i inside {OP_BSET, OP_BCLR, OP_SWR}) |=> (sreg_o[F_I] == $past(sreg_i[F_I])));

  p_swr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SWR) |=> (sreg_o == $past(a_i)));
endmodule

bind alu8_status alu8_status_chk u_chk (.*);

// File: tb/alu8_status_tb.sv
module alu8_status_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0, sreg = '0;
  logic [5:0] k = '0;
  logic [2:0] sel = '0;
  logic [7:0] res, res_hi, sreg_out;

  int checks = 0, failures = 0;
  logic [23:0] exp_prev = '0;
  string req_prev = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  alu8_status u_dut (.clk_i(clk), .rst_ni(rst_ni), .op_i(op), .a_i(a), .b_i(b),
                     .k_i(k), .sel_i(sel), .sreg_i(sreg), .res_o(res),
                     .res_hi_o(res_hi), .sreg_o(sreg_out));

  function automatic string req_of(int o);
    case (o)
      0, 1: return "R3";
      2, 3, 4, 5: return "R4";
      6, 7, 8, 9: return "R5";
      10, 11, 12: return "R6";
      13, 14: return "R7";
      15: return "R8";
      16, 17: return "R9";
      18, 19: return "R10";
      20: return "R11";
      21, 22: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic int sgn(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // returns {hi, res, status}
  function automatic logic [23:0] model(int o, int av, int bv, int kv, int sv, int st);
    int r = av, hi = bv, c, h, v, sum, w;
    bit flag = 1, keep_c = 0, keep_h = 1;
    logic [7:0] ns = st[7:0];
    logic [7:0] ab = av[7:0];
    c = st & 1; h = (st >> 5) & 1; v = 0;
    case (o)
      0, 1: begin
        sum = av + bv + ((o == 1) ? c : 0);
        h = ((av % 16) + (bv % 16) + ((o == 1) ? (st & 1) : 0)) > 15;
        v = (sgn(av) + sgn(bv) + ((o == 1) ? (st & 1) : 0)) > 127 ||
            (sgn(av) + sgn(bv) + ((o == 1) ? (st & 1) : 0)) < -128;
        c = sum > 255; r = sum % 256;
      end
      2: begin r = (av - bv + 256) % 256; c = av < bv; h = (av % 16) < (bv % 16);
               v = (sgn(av) - sgn(bv)) > 127 || (sgn(av) - sgn(bv)) < -128; end
      3: begin r = (256 - av) % 256; c = av != 0; h = (av % 16) != 0; v = av == 128; end
      4: begin r = (av + 1) % 256; v = av == 127; end
      5: begin r = (av + 255) % 256; v = av == 128; end
      6: r = av & bv;
      7: r = av | bv;
      8: r = av ^ bv;
      9: begin r = 255 - av; c = 1; end
      10: begin r = (av * 2) % 256; c = av / 128; h = ab[3]; end
      11: begin r = av / 2; c = av % 2; end
      12: begin r = av / 2 + (av & 128); c = av % 2; end
      13: begin r = (av * 2) % 256 + (st & 1); c = av / 128; h = ab[3]; end
      14: begin r = av / 2 + 128 * (st & 1); c = av % 2; end
      15: begin r = (av % 16) * 16 + av / 16; flag = 0; end
      16: begin ns[6] = ab[sv]; flag = 0; end
      17: begin flag = 0; if (st[6]) r = av | (1 << sv); else r = av & ~(1 << sv); end
      18: begin ns[sv] = 1'b1; flag = 0; end
      19: begin ns[sv] = 1'b0; flag = 0; end
      20: begin
        w = bv * 256 + av + kv; flag = 0;
        ns[0] = w > 65535; w = w % 65536;
        r = w % 256; hi = w / 256;
        ns[2] = w >= 32768; ns[3] = (bv < 128) && (w >= 32768);
        ns[1] = w == 0; ns[4] = ns[2] ^ ns[3];
      end
      21: begin r = st; flag = 0; end
      22: begin ns = ab; flag = 0; end
      default: flag = 0;
    endcase
    if (o >= 10 && o <= 14) v = ((r / 128) ^ c);
    if (flag) begin
      if (!(o == 4 || o == 5)) ns[0] = c[0];
      if (o <= 3 || o == 10 || o == 13) ns[5] = h[0];
      ns[3] = v[0]; ns[2] = r >= 128; ns[1] = r == 0; ns[4] = (r >= 128) ^ v[0];
    end
    return {hi[7:0], r[7:0], ns};
  endfunction

  task automatic compare(logic [23:0] e, string rq, string what);
    checks++;
    if ({res_hi, res, sreg_out} !== e) begin
      failures++;
      $display("FAIL %s %s: got hi=%h res=%h sreg=%h expected hi=%h res=%h sreg=%h",
               rq, what, res_hi, res, sreg_out, e[23:16], e[15:8], e[7:0]);
    end
  endtask

  task automatic step(int o, int av, int bv, int kv, int sv, int st);
    @(negedge clk);
    compare(exp_prev, req_prev, "result one edge after inputs");
    op = 5'(o); a = 8'(av); b = 8'(bv); k = 6'(kv); sel = 3'(sv); sreg = 8'(st);
    #1;
    compare(exp_prev, "R2", "outputs held until the edge");
    exp_prev = model(o, av, bv, kv, sv, st);
    req_prev = req_of(o);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    op = 5'd0; a = 8'hff; b = 8'h01; sreg = 8'hff;
    #23;
    compare(24'h0, "R1", "reset state");
    @(negedge clk); #2;
    compare(24'h0, "R1", "reset state held");
    rst_ni = 1'b1;
    exp_prev = model(0, 8'hff, 8'h01, 0, 0, 8'hff);
    req_prev = "R3";
    // R3 adds
    step(0, 8'h7f, 8'h01, 0, 0, 8'h00);
    step(0, 8'h0f, 8'h01, 0, 0, 8'h00);
    step(0, 8'hff, 8'h01, 0, 0, 8'h00);
    step(1, 8'h80, 8'h7f, 0, 0, 8'h01);
    step(1, 8'h80, 8'h80, 0, 0, 8'h00);
    // R4
    step(2, 8'h00, 8'h01, 0, 0, 8'h00);
    step(2, 8'h80, 8'h01, 0, 0, 8'h00);
    step(3, 8'h80, 8'h00, 0, 0, 8'h00);
    step(3, 8'h00, 8'h00, 0, 0, 8'h21);
    step(4, 8'h7f, 8'h00, 0, 0, 8'h21);
    step(5, 8'h80, 8'h00, 0, 0, 8'h00);
    step(5, 8'h01, 8'h00, 0, 0, 8'h01);
    // R5
    step(6, 8'hf0, 8'h0f, 0, 0, 8'h09);
    step(7, 8'h80, 8'h01, 0, 0, 8'h00);
    step(8, 8'haa, 8'haa, 0, 0, 8'h08);
    step(9, 8'hff, 8'h00, 0, 0, 8'h00);
    // R6 / R7
    step(10, 8'h88, 8'h00, 0, 0, 8'h00);
    step(11, 8'h01, 8'h00, 0, 0, 8'h00);
    step(12, 8'h81, 8'h00, 0, 0, 8'h00);
    step(13, 8'h80, 8'h00, 0, 0, 8'h01);
    step(14, 8'h01, 8'h00, 0, 0, 8'h01);
    step(14, 8'h00, 8'h00, 0, 0, 8'h00);
    // R8 / R9 / R10
    step(15, 8'h3c, 8'h00, 0, 0, 8'h5a);
    step(16, 8'h20, 8'h00, 0, 5, 8'h00);
    step(16, 8'hdf, 8'h00, 0, 5, 8'hff);
    step(17, 8'h00, 8'h00, 0, 7, 8'h40);
    step(17, 8'hff, 8'h00, 0, 2, 8'h00);
    step(18, 8'h11, 8'h00, 0, 7, 8'h00);
    step(19, 8'h11, 8'h00, 0, 0, 8'hff);
    // R11
    step(20, 8'hff, 8'hff, 1, 0, 8'h00);
    step(20, 8'hff, 8'h7f, 1, 0, 8'h00);
    step(20, 8'hc2, 8'h12, 63, 0, 8'hff);
    step(20, 8'h00, 8'h00, 0, 0, 8'h00);
    // R12 / R13
    step(21, 8'h00, 8'h00, 0, 0, 8'ha5);
    step(22, 8'h5a, 8'h00, 0, 0, 8'ha5);
    step(31, 8'h77, 8'h66, 5, 3, 8'h3c);
    step(23, 8'h01, 8'h02, 0, 0, 8'hc3);
    for (int i = 0; i < 4000; i++)
      step(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 63)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 255)));
    @(negedge clk);
    compare(exp_prev, req_prev, "final vector");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule